// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO serial bus. Software writes a clock divisor, a PHY address and a PHY register number through a 32-bit word-addressed register bus. It then starts a transfer in one of two ways. Writing the write-data register sends that value to the PHY at once. Raising the read request bit in the command register fetches a value from the PHY.

Each transfer is a 64-bit Clause 22 frame, sent most significant bit first. The frame holds 32 preamble ones, the start pattern 01, an opcode, the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits. The block drives MDC from the system clock only while a frame runs. It updates MDIO when MDC falls and samples returning data when MDC rises. Software polls a busy flag to learn that a frame has finished. For a read, it then collects the 16 returned bits from the read-data register. The read request is a level that software clears itself. A second read needs the bit to go low and then high again.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every register reads 0, MDC is low and the MDIO output enable is low.
- R2: Register offsets. 0x00 is the divisor and reads back its low DIV_W bits. 0x04 is the command register: bit 0 requests a read, bit 1 is the reserved scan bit, and both read back. 0x08 holds the PHY address in bits 12:8 and the register number in bits 4:0, and its other bits read 0. 0x0C holds write data in bits 15:0. 0x10 is read data. 0x14 bit 0 is busy.
- R3: A bus write to 0x0C while idle sends a write frame carrying bits 15:0 of the written value. The frame is 32 ones, then 01, then opcode 01, the PHY address, the register number, turnaround 10 and the data.
- R4: A read frame (opcode 10) starts only when command bit 0 goes from 0 to 1 while idle. Writing 1 again while it already holds 1 starts nothing.
- R5: The output enable stays high for the whole of a write frame. In a read frame it is high up to the first turnaround bit and low from the second turnaround bit through the data. It is low when idle.
- R6: A read frame samples MDIO-in on the 16 MDC rising edges of the data phase, first bit received becoming bit 15. The result appears at 0x10 when the frame ends, and bus writes to 0x10 have no effect.
- R7: Busy reads 1 from the cycle after a launch for exactly 128 times the MDC half period in system clocks, then reads 0.
- R8: The MDC half period is the divisor in system clocks, with 0 treated as 1. MDC is low when idle. MDIO-out changes only while MDC is low.
- R9: Register writes made while busy are stored, but they neither start nor restart a frame.
- R10: Setting command bit 1 (scan) stores the bit and starts no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register; bits 1:0 are ignored |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
A wrong bit counter or shift register appears on MDIO-out within one MDC period as a misplaced opcode, address or data bit. It also changes the busy duration, which the bench measures to the exact system cycle. A divider fault shows in the first pair of MDC rising edges. Faults in launch decoding show either as a frame that never ends or as a frame that starts when it should not. In the second case busy reads 1, or MDC moves, within a few cycles of the stray register write. A fault in read capture only shows at the read-data register after the frame ends, so the bench compares that register with the pattern its PHY model sent.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA2_IDX    = 47;   // second turnaround bit
  localparam int DATA_IDX   = 48;   // first data bit
  localparam int PHY_W      = 5;
  localparam int REGN_W     = 5;
  localparam int DATA_W     = 16;

  // word index of each register (byte offset / 4)
  localparam int SEL_CFG  = 0;
  localparam int SEL_CMD  = 1;
  localparam int SEL_ADDR = 2;
  localparam int SEL_CTRL = 3;
  localparam int SEL_STAT = 4;
  localparam int SEL_IND  = 5;

  // Full serial frame, bit 63 goes out first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              is_rd,
    input logic [PHY_W-1:0]  phy,
    input logic [REGN_W-1:0] regn,
    input logic [DATA_W-1:0] data);
    logic [1:0] op;
    logic [1:0] ta;
    op = is_rd ? 2'b10 : 2'b01;
    ta = is_rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, (is_rd ? '0 : data)};
  endfunction
endpackage

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DIV_W-1:0]  div,
  output logic [PHY_W-1:0]  phy,
  output logic [REGN_W-1:0] regn,
  output logic [DATA_W-1:0] frame_data,
  output logic              start,
  output logic              start_rd
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]  sel;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        cmd_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REGN_W-1:0] regn_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              wr_cfg, wr_cmd, wr_addr, wr_ctrl;
  logic              launch_rd, launch_wr;
  logic              unused_bits;

  assign sel     = bus_addr[ADDR_W-1:2];
  assign wr_cfg  = bus_wr && (sel == SEL_W'(SEL_CFG));
  assign wr_cmd  = bus_wr && (sel == SEL_W'(SEL_CMD));
  assign wr_addr = bus_wr && (sel == SEL_W'(SEL_ADDR));
  assign wr_ctrl = bus_wr && (sel == SEL_W'(SEL_CTRL));

  // read launches on a 0->1 change of the stored request bit
  assign launch_rd = wr_cmd && bus_wdata[0] && !cmd_q[0] && !busy;
  assign launch_wr = wr_ctrl && !busy;
  assign start     = launch_rd || launch_wr;
  assign start_rd  = launch_rd;

  assign frame_data = launch_wr ? bus_wdata[DATA_W-1:0] : ctrl_q;
  assign div  = div_q;
  assign phy  = phy_q;
  assign regn = regn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cmd_q  <= '0;
      phy_q  <= '0;
      regn_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_cfg)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_cmd)  cmd_q  <= bus_wdata[1:0];
      if (wr_addr) begin
        phy_q  <= bus_wdata[8 +: PHY_W];
        regn_q <= bus_wdata[REGN_W-1:0];
      end
      if (wr_ctrl) ctrl_q <= bus_wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_W'(SEL_CFG):  bus_rdata[DIV_W-1:0]  = div_q;
      SEL_W'(SEL_CMD):  bus_rdata[1:0]        = cmd_q;
      SEL_W'(SEL_ADDR): begin
        bus_rdata[8 +: PHY_W]   = phy_q;
        bus_rdata[REGN_W-1:0]   = regn_q;
      end
      SEL_W'(SEL_CTRL): bus_rdata[DATA_W-1:0] = ctrl_q;
      SEL_W'(SEL_STAT): bus_rdata[DATA_W-1:0] = rd_data;
      SEL_W'(SEL_IND):  bus_rdata[0]          = busy;
      default:          bus_rdata = '0;
    endcase
  end

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:DATA_W]};

  // write data stored even while a frame runs
  assert_busy_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy) |=> (ctrl_q == $past(bus_wdata[DATA_W-1:0])));
endmodule

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] hp_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap      = run && !restart && (cnt_q == hp_q - DIV_W'(1));
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hp_q  <= DIV_W'(1);
      mdc_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      hp_q  <= half_period(div);
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < hp_q));
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REGN_W-1:0] regn,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;
  logic                  op_rd_q;
  logic                  oe_q;
  logic [DATA_W-1:0]     rx_q;
  logic [DATA_W-1:0]     rd_q;
  logic                  last_bit;
  logic                  in_data;

  assign last_bit = (idx_q == IDX_W'(FRAME_BITS-1));
  assign in_data  = (idx_q >= IDX_W'(DATA_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      oe_q    <= 1'b0;
      rx_q    <= '0;
      rd_q    <= '0;
    end else if (start) begin
      frame_q <= build_frame(start_rd, phy, regn, frame_data);
      idx_q   <= '0;
      busy_q  <= 1'b1;
      op_rd_q <= start_rd;
      oe_q    <= 1'b1;
      rx_q    <= '0;
    end else if (busy_q) begin
      if (rise_tick && op_rd_q && in_data)
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          busy_q  <= 1'b0;
          oe_q    <= 1'b0;
          frame_q <= '0;
          if (op_rd_q) rd_q <= rx_q;
        end else begin
          idx_q   <= idx_q + IDX_W'(1);
          frame_q <= frame_q << 1;
          oe_q    <= !(op_rd_q && (idx_q >= IDX_W'(TA2_IDX - 1)));
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = frame_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign rd_data = rd_q;

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (idx_q >= $past(idx_q)));
  assert_oe_read_ta_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_rd_q && idx_q >= IDX_W'(TA2_IDX)) |-> !mdio_oe);
  assert_oe_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !op_rd_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]  div;
  logic [PHY_W-1:0]  phy;
  logic [REGN_W-1:0] regn;
  logic [DATA_W-1:0] frame_data;
  logic [DATA_W-1:0] rd_data;
  logic              start, start_rd, busy;
  logic              rise_tick, fall_tick;

  mdio_csr #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy(busy), .rd_data(rd_data),
    .div(div), .phy(phy), .regn(regn), .frame_data(frame_data),
    .start(start), .start_rd(start_rd)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n),
    .run(busy), .restart(start), .div(div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_rd(start_rd),
    .phy(phy), .regn(regn), .frame_data(frame_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  assert_mdc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));
  assert_end_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // rd, div, phy, reg, data
  localparam logic [34:0] VEC [6] = '{
    {1'b0, 8'd2, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 8'd1, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 8'd3, 5'h10, 5'h0A, 16'hFFFF},
    {1'b1, 8'd2, 5'h00, 5'h01, 16'h1234},
    {1'b0, 8'd1, 5'h15, 5'h11, 16'h0000},
    {1'b1, 8'd0, 5'h0A, 5'h15, 16'h5A5A}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_vector(input logic rd, input logic [7:0] dv, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] dat);
    logic [63:0] got, goe, exp_f, exp_oe;
    int t0, t1, n, hp;
    logic [31:0] v;
    hp = (dv == 0) ? 1 : int'(dv);
    t0 = 0; t1 = 0; n = 0; got = '0; goe = '0;
    bus_write(5'h00, {24'h0, dv});
    bus_write(5'h08, {19'h0, phy, 3'h0, rg});
    if (rd) bus_write(5'h04, 32'h0);
    fork
      begin
        for (int k = 0; k < 64; k++) begin
          @(posedge mdc); #1;
          got[63-k] = mdio_o; goe[63-k] = mdio_oe;
          if (k == 0) t0 = cyc;
          if (k == 1) t1 = cyc;
          @(negedge mdc); #1;
          mdio_i = (k >= 47 && k <= 62) ? dat[62-k] : 1'b1;
        end
      end
      begin
        if (rd) bus_write(5'h04, 32'h1);
        else    bus_write(5'h0C, {16'h0, dat});
        bus_addr = 5'h14;
        #1;
        while (bus_rdata[0] === 1'b1) begin
          n++;
          @(negedge clk); #1;
        end
      end
    join
    exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, dat};
    exp_oe = rd ? {{47{1'b1}}, 17'b0} : {64{1'b1}};
    if (rd) chk("R4 read frame header", {18'h0, got[63:18]}, {18'h0, exp_f[63:18]});
    else    chk("R3 write frame", got, exp_f);
    chk("R5 output enable pattern", goe, exp_oe);
    chk("R8 MDC period", 64'(t1 - t0), 64'(2*hp));
    chk("R7 busy duration", 64'(n), 64'(128*hp));
    if (rd) begin
      bus_read(5'h10, v);
      chk("R6 read data", {32'h0, v}, {48'h0, dat});
    end else begin
      bus_read(5'h0C, v);
      chk("R2 write data readback", {32'h0, v}, {48'h0, dat});
    end
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_read(5'(a*4), v);
      chk("R1 register reset", {32'h0, v}, 64'h0);
    end
    chk("R1 mdc low", {63'h0, mdc}, 64'h0);
    chk("R1 oe low", {63'h0, mdio_oe}, 64'h0);

    // R2 readback masks
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_read(5'h00, v);
    chk("R2 divisor readback", {32'h0, v}, 64'h0000_00FF);
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, v);
    chk("R2 address readback", {32'h0, v}, 64'h0000_1F1F);
    bus_read(5'h14, v);
    chk("R2 no launch on address write", {32'h0, v}, 64'h0);

    // table of frames
    for (int i = 0; i < 6; i++)
      run_vector(VEC[i][34], VEC[i][33:26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);

    // R4: request bit already 1, writing 1 again must not start
    bus_write(5'h04, 32'h1);
    repeat (10) @(negedge clk);
    #1;
    chk("R4 held bit no launch mdc", {63'h0, mdc}, 64'h0);
    bus_read(5'h14, v);
    chk("R4 held bit no launch busy", {32'h0, v}, 64'h0);

    // R9: writes during a frame are stored, no restart
    bus_write(5'h00, 32'h1);
    bus_write(5'h0C, 32'h0F0F);
    bus_write(5'h0C, 32'h3333);
    bus_write(5'h04, 32'h0);
    bus_write(5'h04, 32'h1);
    bus_addr = 5'h14;
    #1;
    n = 0;
    while (bus_rdata[0] === 1'b1) begin
      n++;
      @(negedge clk); #1;
    end
    chk("R9 frame not restarted", 64'(n), 64'd122);
    bus_read(5'h0C, v);
    chk("R9 write data stored while busy", {32'h0, v}, 64'h3333);
    bus_read(5'h04, v);
    chk("R9 command stored while busy", {32'h0, v}, 64'h1);
    repeat (10) @(negedge clk);
    bus_read(5'h14, v);
    chk("R9 no late launch", {32'h0, v}, 64'h0);

    // R10: scan bit does nothing
    bus_write(5'h04, 32'h0);
    bus_write(5'h04, 32'h2);
    repeat (8) @(negedge clk);
    #1;
    chk("R10 scan mdc idle", {63'h0, mdc}, 64'h0);
    bus_read(5'h14, v);
    chk("R10 scan no busy", {32'h0, v}, 64'h0);
    bus_read(5'h04, v);
    chk("R10 scan bit stored", {32'h0, v}, 64'h2);

    // R6: read-data register ignores bus writes
    bus_write(5'h10, 32'hFFFF_FFFF);
    bus_read(5'h10, v);
    chk("R6 read data not writable", {32'h0, v}, 64'h5A5A);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule